// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the data-register side of a boundary scan port for a configurable row of pads. Each pad is one of four kinds: input only, output only, output with a tristate enable, or fully bidirectional. A pad gets one scan cell for each signal it carries, so the chain length is the sum of the per-kind cell counts. An input pad has one cell, an output pad one, a tristate output two and a bidirectional pad three. The default row holds one pad of each kind, which gives a 7-cell chain.

A test access port controller outside this block supplies the current instruction, the serial input and the capture, shift and update strobes. The block returns the serial output. Under the sample/preload instruction the chain takes a snapshot of the live pad and core values while the pads keep working normally. Under the external-test instruction the pads and the core-facing inputs are driven from the cells' update latches. The block also holds a 32-bit identification register and a single-bit bypass register, so that every instruction code has something to shift.

Top module: `bscan_chain`

## Requirements
- R1: The chain holds one cell per pad signal: 1 for an input pad, 1 for an output pad, 2 for a tristate output and 3 for a bidirectional pad. With the default pads (kinds input, output, tristate, bidirectional for pads 0..3) a bit entering `tdi` reaches `tdo` after exactly 7 shifts.
- R2: Cells are numbered from `tdo`. Cell 0 is the cell driving `tdo`. Pads take cells in pad-list order, and within a pad the order is input, output, enable. Each shift moves every cell one place toward `tdo` and loads `tdi` into the last cell.
- R3: When the chain is selected, `capture_dr` loads each input cell from `pad_i`, each output cell from `core_o` and each enable cell from `core_oe` of its pad.
- R4: For every instruction other than code 0, pads run normally. Output-carrying pads drive `pad_o = core_o`. Tristate and bidirectional pads drive `pad_oe = core_oe`. An output-only pad drives `pad_oe = 1`. An input-only pad drives `pad_o = 0` and `pad_oe = 0`. Pads with an input cell pass `pad_i` to `core_i`, and other pads give `core_i = 0`.
- R5: Under code 0 (external test), `pad_o`, `pad_oe` and `core_i` of every pad that owns the matching cell come from that cell's update latch, whatever `core_o`, `core_oe` and `pad_i` are doing.
- R6: Update latches load the chain contents on `update_dr` only while code 0 or code 2 is selected. Otherwise they keep their value.
- R7: Synchronous reset clears all chain cells and update latches. Under code 0 straight after reset, every pad drives 0 and only the output-only pad keeps its enable set.
- R8: Code 1 selects a 32-bit register that `capture_dr` loads with 0x000018FF and that shifts out least significant bit first.
- R9: Every code other than 0, 1 and 2 selects a one-bit bypass register. Capture loads it with 0, and `tdi` appears on `tdo` one shift later.
- R10: Strobes given while the chain is not selected leave the chain cells and update latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test-logic reset |
| ir | input | IR_W | Current instruction code |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Capture strobe for the selected register |
| shift_dr | input | 1 | Shift strobe for the selected register |
| update_dr | input | 1 | Update strobe for the chain latches |
| tdo | output | 1 | Serial data out of the selected register |
| core_i | output | NUM_PADS | Pad input value as seen by the core |
| core_o | input | NUM_PADS | Output value requested by the core |
| core_oe | input | NUM_PADS | Output enable requested by the core |
| pad_i | input | NUM_PADS | Value arriving from each pad |
| pad_o | output | NUM_PADS | Value driven onto each pad |
| pad_oe | output | NUM_PADS | Output enable driven onto each pad |

## Verification
The assertions check on every cycle the properties that can be stated locally. These are: shifting moves `tdi` into the far end of the chain, strobes under another instruction leave the chain and latches alone, pads stay frozen under external test unless an update arrives, the latches are clear after reset, and the bypass and identification registers show the expected `tdo` one cycle after a shift or capture. Only the bench scenarios can show that the whole chain is exactly 7 cells long, that the cells sit in pad and signal order, that a capture takes the correct live values, and that a preload made under sample/preload later appears on the pads under external test. The bench's cycle model also confirms that changes to the core inputs never reach the pads during external test.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        PK_INPUT  = 2'd0,
        PK_OUTPUT = 2'd1,
        PK_TRIOUT = 2'd2,
        PK_BIDIR  = 2'd3
    } pad_kind_e;

    typedef enum logic [1:0] {
        ROLE_IN  = 2'd0,
        ROLE_OUT = 2'd1,
        ROLE_EN  = 2'd2
    } cell_role_e;

    // One pad's three signals, used for latch views and capture values.
    typedef struct packed {
        logic in_v;
        logic out_v;
        logic en_v;
    } pad_sig_t;

    localparam int OP_EXTEST = 0;
    localparam int OP_IDCODE = 1;
    localparam int OP_SAMPLE = 2;

    localparam int KIND_VEC_W = 128;

    function automatic logic [1:0] kind_at(logic [KIND_VEC_W-1:0] kinds, int p);
        return kinds[2*p +: 2];
    endfunction

    function automatic int has_in(logic [1:0] k);
        return (k == PK_INPUT || k == PK_BIDIR) ? 1 : 0;
    endfunction

    function automatic int has_out(logic [1:0] k);
        return (k != PK_INPUT) ? 1 : 0;
    endfunction

    function automatic int has_en(logic [1:0] k);
        return (k == PK_TRIOUT || k == PK_BIDIR) ? 1 : 0;
    endfunction

    function automatic int cells_of(logic [1:0] k);
        return has_in(k) + has_out(k) + has_en(k);
    endfunction

    // Index of the first cell of pad p.
    function automatic int pad_base(logic [KIND_VEC_W-1:0] kinds, int p);
        int acc;
        acc = 0;
        for (int q = 0; q < p; q++) acc += cells_of(kind_at(kinds, q));
        return acc;
    endfunction

    function automatic int chain_len(logic [KIND_VEC_W-1:0] kinds, int n);
        return pad_base(kinds, n);
    endfunction

    function automatic int cell_owner(logic [KIND_VEC_W-1:0] kinds, int n, int c);
        for (int p = 0; p < n; p++)
            if (c < pad_base(kinds, p + 1)) return p;
        return 0;
    endfunction

    function automatic cell_role_e cell_role(logic [KIND_VEC_W-1:0] kinds, int n, int c);
        int p;
        int off;
        logic [1:0] k;
        p   = cell_owner(kinds, n, c);
        off = c - pad_base(kinds, p);
        k   = kind_at(kinds, p);
        if (has_in(k) != 0) begin
            if (off == 0) return ROLE_IN;
            off--;
        end
        if (off == 0) return ROLE_OUT;
        return ROLE_EN;
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic cap_d,
    input  logic si,
    output logic so,
    output logic lat
);

    logic sr_q;
    logic lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= 1'b0;
        end else if (cap_en) begin
            sr_q <= cap_d;
        end else if (shift_en) begin
            sr_q <= si;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= 1'b0;
        end else if (upd_en) begin
            lat_q <= sr_q;
        end
    end

    assign so  = sr_q;
    assign lat = lat_q;

endmodule

// File: rtl/bscan_pad.sv
module bscan_pad
    import bscan_pkg::*;
#(
    parameter logic [1:0] KIND = PK_BIDIR
) (
    input  logic     extest,
    input  logic     core_o,
    input  logic     core_oe,
    input  logic     pad_i,
    input  pad_sig_t lat,
    output logic     core_i,
    output logic     pad_o,
    output logic     pad_oe,
    output pad_sig_t cap
);

    assign cap = '{in_v: pad_i, out_v: core_o, en_v: core_oe};

    generate
        if (KIND == PK_INPUT) begin : g_in
            assign core_i = extest ? lat.in_v : pad_i;
            assign pad_o  = 1'b0;
            assign pad_oe = 1'b0;
        end else if (KIND == PK_OUTPUT) begin : g_out
            assign core_i = 1'b0;
            assign pad_o  = extest ? lat.out_v : core_o;
            assign pad_oe = 1'b1;
        end else if (KIND == PK_TRIOUT) begin : g_tri
            assign core_i = 1'b0;
            assign pad_o  = extest ? lat.out_v : core_o;
            assign pad_oe = extest ? lat.en_v  : core_oe;
        end else begin : g_bidir
            assign core_i = extest ? lat.in_v  : pad_i;
            assign pad_o  = extest ? lat.out_v : core_o;
            assign pad_oe = extest ? lat.en_v  : core_oe;
        end
    endgenerate

endmodule

// File: rtl/bscan_aux.sv
module bscan_aux #(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0000_18ff
) (
    input  logic clk,
    input  logic rst,
    input  logic id_sel,
    input  logic byp_sel,
    input  logic capture,
    input  logic shift,
    input  logic tdi,
    output logic id_tdo,
    output logic byp_tdo
);

    logic [ID_W-1:0] id_q;
    logic            byp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= '0;
        end else if (id_sel && capture) begin
            id_q <= ID_W'(ID_VALUE);
        end else if (id_sel && shift) begin
            id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= 1'b0;
        end else if (byp_sel && capture) begin
            byp_q <= 1'b0;
        end else if (byp_sel && shift) begin
            byp_q <= tdi;
        end
    end

    assign id_tdo  = id_q[0];
    assign byp_tdo = byp_q;

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int                  NUM_PADS  = 4,
    parameter logic [2*NUM_PADS-1:0] PAD_KINDS = 8'hE4,
    parameter int                  IR_W      = 4,
    parameter logic [31:0]         ID_VALUE  = 32'h0000_18ff
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IR_W-1:0]     ir,
    input  logic                tdi,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    output logic                tdo,
    output logic [NUM_PADS-1:0] core_i,
    input  logic [NUM_PADS-1:0] core_o,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic [NUM_PADS-1:0] pad_i,
    output logic [NUM_PADS-1:0] pad_o,
    output logic [NUM_PADS-1:0] pad_oe
);

    localparam logic [KIND_VEC_W-1:0] KINDS_W = KIND_VEC_W'(PAD_KINDS);
    localparam int CHAIN_LEN = chain_len(KINDS_W, NUM_PADS);

    logic sel_ext;
    logic sel_smp;
    logic chain_sel;
    logic id_sel;
    logic byp_sel;

    assign sel_ext   = (ir == IR_W'(OP_EXTEST));
    assign sel_smp   = (ir == IR_W'(OP_SAMPLE));
    assign chain_sel = sel_ext | sel_smp;
    assign id_sel    = (ir == IR_W'(OP_IDCODE));
    assign byp_sel   = !chain_sel && !id_sel;

    logic [CHAIN_LEN-1:0] chain_q;
    logic [CHAIN_LEN-1:0] upd_q;
    logic [CHAIN_LEN-1:0] cap_val;

    pad_sig_t lat_v [NUM_PADS];
    pad_sig_t cap_v [NUM_PADS];

    // Scan cells, cell 0 next to tdo.
    generate
        for (genvar c = 0; c < CHAIN_LEN; c++) begin : g_cell
            localparam int         OWNER = cell_owner(KINDS_W, NUM_PADS, c);
            localparam cell_role_e ROLE  = cell_role(KINDS_W, NUM_PADS, c);
            logic si_c;

            if (c == CHAIN_LEN - 1) begin : g_last
                assign si_c = tdi;
            end else begin : g_mid
                assign si_c = chain_q[c+1];
            end

            if (ROLE == ROLE_IN) begin : g_ci
                assign cap_val[c] = cap_v[OWNER].in_v;
            end else if (ROLE == ROLE_OUT) begin : g_co
                assign cap_val[c] = cap_v[OWNER].out_v;
            end else begin : g_ce
                assign cap_val[c] = cap_v[OWNER].en_v;
            end

            bscan_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .cap_en   (chain_sel && capture_dr),
                .shift_en (chain_sel && shift_dr),
                .upd_en   (chain_sel && update_dr),
                .cap_d    (cap_val[c]),
                .si       (si_c),
                .so       (chain_q[c]),
                .lat      (upd_q[c])
            );
        end
    endgenerate

    // Pad muxes, one per pad, variant chosen by kind.
    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
            localparam logic [1:0] KIND  = kind_at(KINDS_W, p);
            localparam int         BASE  = pad_base(KINDS_W, p);
            localparam int         HI    = has_in(KIND);
            localparam int         HO    = has_out(KIND);
            localparam int         HE    = has_en(KIND);
            localparam int         I_IDX = BASE;
            localparam int         O_IDX = (HO != 0) ? BASE + HI : 0;
            localparam int         E_IDX = (HE != 0) ? BASE + HI + HO : 0;

            assign lat_v[p] = '{
                in_v:  (HI != 0) ? upd_q[I_IDX] : 1'b0,
                out_v: (HO != 0) ? upd_q[O_IDX] : 1'b0,
                en_v:  (HE != 0) ? upd_q[E_IDX] : 1'b0
            };

            bscan_pad #(.KIND(KIND)) u_pad (
                .extest  (sel_ext),
                .core_o  (core_o[p]),
                .core_oe (core_oe[p]),
                .pad_i   (pad_i[p]),
                .lat     (lat_v[p]),
                .core_i  (core_i[p]),
                .pad_o   (pad_o[p]),
                .pad_oe  (pad_oe[p]),
                .cap     (cap_v[p])
            );
        end
    endgenerate

    logic id_tdo;
    logic byp_tdo;

    bscan_aux #(.ID_W(32), .ID_VALUE(ID_VALUE)) u_aux (
        .clk     (clk),
        .rst     (rst),
        .id_sel  (id_sel),
        .byp_sel (byp_sel),
        .capture (capture_dr),
        .shift   (shift_dr),
        .tdi     (tdi),
        .id_tdo  (id_tdo),
        .byp_tdo (byp_tdo)
    );

    always_comb begin
        if (chain_sel)   tdo = chain_q[0];
        else if (id_sel) tdo = id_tdo;
        else             tdo = byp_tdo;
    end

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int   NUM_PADS  = 4,
    parameter int   CHAIN_LEN = 7,
    parameter int   IR_W      = 4,
    parameter logic ID_LSB    = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [IR_W-1:0]      ir,
    input logic                 tdi,
    input logic                 tdo,
    input logic                 capture_dr,
    input logic                 shift_dr,
    input logic                 update_dr,
    input logic [NUM_PADS-1:0]  pad_o,
    input logic [NUM_PADS-1:0]  pad_oe,
    input logic [CHAIN_LEN-1:0] chain_q,
    input logic [CHAIN_LEN-1:0] upd_q
);

    logic c_ext;
    logic c_chain;
    logic c_id;
    logic c_byp;

    assign c_ext   = (ir == IR_W'(0));
    assign c_chain = c_ext || (ir == IR_W'(2));
    assign c_id    = (ir == IR_W'(1));
    assign c_byp   = !c_chain && !c_id;

    AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (upd_q == '0)); // R7

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (c_chain && shift_dr && !capture_dr) |=> (chain_q[CHAIN_LEN-1] == $past(tdi))); // R2

    AST_HOLD_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
        !c_chain |=> ($stable(chain_q) && $stable(upd_q))); // R10

    AST_EXTEST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (c_ext && !update_dr) |=> (!c_ext || ($stable(pad_o) && $stable(pad_oe)))); // R6

    AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (rst)
        (c_byp && shift_dr && !capture_dr) |=> (!c_byp || (tdo == $past(tdi)))); // R9

    AST_ID_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
        (c_id && capture_dr) |=> (!c_id || (tdo == ID_LSB))); // R8

endmodule

bind bscan_chain bscan_chain_chk #(
    .NUM_PADS  (NUM_PADS),
    .CHAIN_LEN (CHAIN_LEN),
    .IR_W      (IR_W),
    .ID_LSB    (ID_VALUE[0])
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ir         (ir),
    .tdi        (tdi),
    .tdo        (tdo),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe),
    .chain_q    (chain_q),
    .upd_q      (upd_q)
);

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] ir;
    logic       tdi;
    logic       capture_dr;
    logic       shift_dr;
    logic       update_dr;
    logic       tdo;
    logic [3:0] core_i;
    logic [3:0] core_o;
    logic [3:0] core_oe;
    logic [3:0] pad_i;
    logic [3:0] pad_o;
    logic [3:0] pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bscan_chain dut (
        .clk        (clk),
        .rst        (rst),
        .ir         (ir),
        .tdi        (tdi),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdo        (tdo),
        .core_i     (core_i),
        .core_o     (core_o),
        .core_oe    (core_oe),
        .pad_i      (pad_i),
        .pad_o      (pad_o),
        .pad_oe     (pad_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 7 cells for pads {input, output, tristate, bidir}.
    // Cell map (R2): 0 pad0.i, 1 pad1.o, 2 pad2.o, 3 pad2.oe, 4 pad3.i, 5 pad3.o, 6 pad3.oe.
    logic [6:0]  m_sr;
    logic [6:0]  m_lat;
    logic [31:0] m_id;
    logic        m_byp;

    always @(posedge clk) begin
        logic       chain;
        logic       ext;
        logic [6:0] old_sr;
        logic [3:0] e_ci;
        logic [3:0] e_po;
        logic [3:0] e_poe;
        logic       e_tdo;
        chain  = (ir == 4'd0) || (ir == 4'd2);
        old_sr = m_sr;
        if (rst) begin
            m_sr  = '0;
            m_lat = '0;
            m_id  = '0;
            m_byp = 1'b0;
        end else begin
            if (chain) begin
                if (capture_dr)
                    m_sr = {core_oe[3], core_o[3], pad_i[3], core_oe[2], core_o[2], core_o[1], pad_i[0]};
                else if (shift_dr)
                    m_sr = {tdi, m_sr[6:1]};
                if (update_dr) m_lat = old_sr;
            end else if (ir == 4'd1) begin
                if (capture_dr)    m_id = 32'h0000_18ff;
                else if (shift_dr) m_id = {tdi, m_id[31:1]};
            end else begin
                if (capture_dr)    m_byp = 1'b0;
                else if (shift_dr) m_byp = tdi;
            end
        end
        #5;
        ext   = (ir == 4'd0);
        chain = (ir == 4'd0) || (ir == 4'd2);
        e_ci  = {ext ? m_lat[4] : pad_i[3], 1'b0, 1'b0, ext ? m_lat[0] : pad_i[0]};
        e_po  = {ext ? m_lat[5] : core_o[3], ext ? m_lat[2] : core_o[2],
                 ext ? m_lat[1] : core_o[1], 1'b0};
        e_poe = {ext ? m_lat[6] : core_oe[3], ext ? m_lat[3] : core_oe[2], 1'b1, 1'b0};
        e_tdo = chain ? m_sr[0] : ((ir == 4'd1) ? m_id[0] : m_byp);
        if (!done) begin
            chk(ext ? "R5 core_i" : "R4 core_i", 64'(core_i), 64'(e_ci));
            chk(ext ? "R5 pad_o"  : "R4 pad_o",  64'(pad_o),  64'(e_po));
            chk(ext ? "R5 pad_oe" : "R4 pad_oe", 64'(pad_oe), 64'(e_poe));
            chk(chain ? "R2 tdo" : ((ir == 4'd1) ? "R8 tdo" : "R9 tdo"), 64'(tdo), 64'(e_tdo));
        end
    end

    task automatic do_capture();
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    task automatic do_shift(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            tdi      = din[i];
            dout[i]  = tdo;
            shift_dr = 1'b1;
            @(negedge clk);
        end
        shift_dr = 1'b0;
        tdi      = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        rst = 1'b1; ir = 4'd0; tdi = 1'b0;
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
        core_o = '0; core_oe = '0; pad_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: reset state under external test
        chk("R7 pad_o",  64'(pad_o),  64'h0);
        chk("R7 pad_oe", 64'(pad_oe), 64'h2);
        chk("R7 core_i", 64'(core_i), 64'h0);

        // R8: identification value
        ir = 4'd1;
        @(negedge clk);
        do_capture();
        do_shift(32, 64'h0, d);
        chk("R8 idcode", d & 64'hFFFF_FFFF, 64'h18ff);

        // R3: sample captures live values; preload 0x59
        core_o = 4'b0100; core_oe = 4'b1100; pad_i = 4'b0001;
        ir = 4'd2;
        @(negedge clk);
        do_capture();
        do_shift(7, 64'h59, d);
        chk("R3 sample capture", d, 64'h4D);
        do_update();
        #1;
        chk("R4 pad_o",  64'(pad_o),  64'h4);
        chk("R4 pad_oe", 64'(pad_oe), 64'hE);
        chk("R4 core_i", 64'(core_i), 64'h1);

        // R5: external test drives from latches 0x59
        ir = 4'd0;
        #1;
        chk("R5 pad_o",  64'(pad_o),  64'h0);
        chk("R5 pad_oe", 64'(pad_oe), 64'hE);
        chk("R5 core_i", 64'(core_i), 64'h9);
        core_o = 4'b1011; core_oe = 4'b0011; pad_i = 4'b1110;
        #1;
        chk("R5 pad_o ignores core", 64'(pad_o),  64'h0);
        chk("R5 pad_oe ignores core", 64'(pad_oe), 64'hE);
        chk("R5 core_i ignores pad", 64'(core_i), 64'h9);
        @(negedge clk);

        // R1: length 7 (captured 0x32, then the first 7 shifted-in bits)
        do_capture();
        do_shift(14, 64'h2D36, d);
        chk("R3 extest capture", d & 64'h7F, 64'h32);
        chk("R1 chain length", (d >> 7) & 64'h7F, 64'h36);
        chk("R6 no update keeps pads", 64'(pad_oe), 64'hE);

        // R10 / R6: strobes under the identification code leave the chain alone
        ir = 4'd1;
        @(negedge clk);
        do_shift(32, 64'hFFFF_FFFF, d);
        do_update();
        ir = 4'd2;
        @(negedge clk);
        do_shift(7, 64'h0, d);
        chk("R10 chain kept", d, 64'h5A);
        ir = 4'd0;
        #1;
        chk("R6 latches kept pad_o",  64'(pad_o),  64'h0);
        chk("R6 latches kept pad_oe", 64'(pad_oe), 64'hE);
        chk("R6 latches kept core_i", 64'(core_i), 64'h9);
        @(negedge clk);

        // R9: bypass
        ir = 4'hF;
        @(negedge clk);
        do_capture();
        do_shift(3, 64'h6, d);
        chk("R9 bypass", d, 64'h4);

        // R7: reset during external test, then normal mode
        ir = 4'd0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R7 reset pad_o",  64'(pad_o),  64'h0);
        chk("R7 reset pad_oe", 64'(pad_oe), 64'h2);
        chk("R7 reset core_i", 64'(core_i), 64'h0);
        ir = 4'd1;
        #1;
        chk("R4 after reset pad_o",  64'(pad_o),  64'hA);
        chk("R4 after reset pad_oe", 64'(pad_oe), 64'h2);
        chk("R4 after reset core_i", 64'(core_i), 64'h8);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule